// File: doc/BRIEF.md
# Masked calendar alarm comparator

This block watches a BCD calendar time and raises an alarm when the time agrees with a programmed alarm setting. The time arrives from an external time counter as six BCD fields: seconds, minutes, hours, day of month, month and a three-digit year. A one-cycle strobe marks each second, asserted in the cycle after the time has advanced. The comparison is made only in strobe cycles.

Software programs the alarm through a simple write port. Address 0 holds the control byte: one enable bit per field and a global enable. Addresses 1 to 6 hold the alarm values. Address 7 is the interrupt-pending register, cleared by writing one. A match sets a sticky pending flag and drives a level interrupt. Both stay high until software clears them.

Top module: `cal_alarm_match`

## Requirements
- R1: After a synchronous reset, alarm_pending and alarm_irq are 0. The control byte and all alarm fields are 0, so enabling only the seconds field with the global enable (control 0x41) matches seconds 00.
- R2: Alarm fields are written at address 1 (seconds), 2 (minutes), 3 (hours), 4 (day of month), 5 (month) and 6 (year). Only the low 7, 7, 6, 6, 5 and 12 bits of wr_data are kept, in that order; higher bits are dropped.
- R3: The control byte at address 0 has one enable bit per field: bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day, bit 4 month, bit 5 year. A field whose bit is 0 takes no part in the match; a field whose bit is 1 must equal its alarm value.
- R4: Control bit 6 is the global enable. When it is 0, no alarm is raised even if every enabled field matches.
- R5: If the global enable is set but all six field enable bits are 0, no alarm is raised.
- R6: The comparison happens only in cycles where sec_strobe is 1. A matching time without the strobe has no effect.
- R7: The year is compared as a whole 12-bit value: the two low BCD digits in bits 7:0 and the hundreds digit in bits 11:8. A difference in the hundreds digit alone prevents a match.
- R8: A match in a strobe cycle sets alarm_pending and alarm_irq at the next clock edge. Both stay at 1 through later strobes that do not match, until they are cleared.
- R9: A write to address 7 with wr_data bit 1 set clears alarm_pending and alarm_irq at that clock edge. A write to address 7 with bit 1 clear leaves them unchanged.
- R10: When a match and a clear arrive in the same cycle, the match wins and the flag stays set.
- R11: A strobe in the same cycle as a write to the control byte or an alarm field is compared against the settings held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_strobe | input | 1 | One-cycle pulse after the time has advanced |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_mday | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| alarm_pending | output | 1 | Sticky alarm-pending flag |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that sec_strobe lasts a single cycle, that the time fields are stable while it is high, and that the write port carries at most one write per cycle. They also take reset as the only path that clears state other than the write-one-to-clear register. The bench drives every input only at the falling edge and holds each value for exactly one rising edge. It pulses the strobe for one cycle at a time, and it changes the time fields only between strobes. Some cases deliberately put a write and a strobe in the same cycle, to cover the priority and old-settings rules.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD    = 6;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 16;
  localparam int CTRL_W    = NFIELD + 1;
  localparam int GLOBAL_EN = NFIELD;
  localparam int PEND_BIT  = 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NFIELD + 1);

  // field order: 0 sec, 1 min, 2 hour, 3 mday, 4 month, 5 year
  function automatic int field_w(input int i);
    case (i)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction

  function automatic int field_lsb(input int i);
    int acc;
    acc = 0;
    for (int k = 0; k < i; k++) acc += field_w(k);
    return acc;
  endfunction

  localparam int TIME_W = field_lsb(NFIELD);

  function automatic logic [ADDR_W-1:0] field_addr(input int i);
    return ADDR_W'(i + 1);
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [TIME_W-1:0] alarm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en && wr_addr == CTRL_ADDR) begin
      ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    localparam int W   = field_w(i);
    localparam int LSB = field_lsb(i);
    logic [W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (wr_en && wr_addr == field_addr(i)) begin
        val_q <= wr_data[W-1:0];
      end
    end
    assign alarm_q[LSB +: W] = val_q;
  end
endmodule

// File: rtl/cal_alarm_field_cmp.sv
module cal_alarm_field_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] now_val,
  input  logic [W-1:0] alarm_val,
  input  logic         use_field,
  output logic         field_ok
);
  always_comb begin
    field_ok = !use_field || (now_val == alarm_val);
  end
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic pend_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (set_req) begin
      pend_q <= 1'b1;
      irq_q  <= 1'b1;
    end else if (clr_req) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_strobe,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_mday,
  input  logic [4:0]        cur_mon,
  input  logic [11:0]       cur_year,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              alarm_pending,
  output logic              alarm_irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [TIME_W-1:0] alarm_q;
  logic [TIME_W-1:0] now_bus;
  logic [NFIELD-1:0] ok_vec;
  logic              alarm_hit;
  logic              clr_req;

  assign now_bus = {cur_year, cur_mon, cur_mday, cur_hour, cur_min, cur_sec};

  cal_alarm_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .alarm_q (alarm_q)
  );

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    localparam int W   = field_w(i);
    localparam int LSB = field_lsb(i);
    cal_alarm_field_cmp #(.W(W)) u_cmp (
      .now_val   (now_bus[LSB +: W]),
      .alarm_val (alarm_q[LSB +: W]),
      .use_field (ctrl_q[i]),
      .field_ok  (ok_vec[i])
    );
  end

  assign alarm_hit = ctrl_q[GLOBAL_EN] && (|ctrl_q[NFIELD-1:0]) && (&ok_vec);
  assign clr_req   = wr_en && (wr_addr == PEND_ADDR) && wr_data[PEND_BIT];

  cal_alarm_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .set_req (sec_strobe && alarm_hit),
    .clr_req (clr_req),
    .pend_q  (alarm_pending),
    .irq_q   (alarm_irq)
  );
endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk
  import cal_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sec_strobe,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CTRL_W-1:0] ctrl,
  input logic              hit,
  input logic              pending,
  input logic              irq
);
  AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq == pending); // R8

  AST_SET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(sec_strobe)); // R6

  AST_SET_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(ctrl[GLOBAL_EN])); // R4

  AST_SET_NEEDS_FIELD: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> $past(|ctrl[NFIELD-1:0])); // R5

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == PEND_ADDR && wr_data[PEND_BIT] && !(sec_strobe && hit))
      |=> !pending); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (sec_strobe && hit) |=> pending); // R10

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pending && !(wr_en && wr_addr == PEND_ADDR && wr_data[PEND_BIT]))
      |=> pending); // R8
endmodule

bind cal_alarm_match cal_alarm_match_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sec_strobe (sec_strobe),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .ctrl       (ctrl_q),
  .hit        (alarm_hit),
  .pending    (alarm_pending),
  .irq        (alarm_irq)
);

// File: tb/cal_alarm_match_test.sv
module cal_alarm_match_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_strobe = 1'b0;
  logic [6:0]  cur_sec = '0;
  logic [6:0]  cur_min = '0;
  logic [5:0]  cur_hour = '0;
  logic [5:0]  cur_mday = '0;
  logic [4:0]  cur_mon = '0;
  logic [11:0] cur_year = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        alarm_pending;
  logic        alarm_irq;

  logic [6:0]  n_sec = '0;
  logic [6:0]  n_min = '0;
  logic [5:0]  n_hour = '0;
  logic [5:0]  n_mday = '0;
  logic [4:0]  n_mon = '0;
  logic [11:0] n_year = '0;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cal_alarm_match uut (
    .clk           (clk),
    .rst           (rst),
    .sec_strobe    (sec_strobe),
    .cur_sec       (cur_sec),
    .cur_min       (cur_min),
    .cur_hour      (cur_hour),
    .cur_mday      (cur_mday),
    .cur_mon       (cur_mon),
    .cur_year      (cur_year),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .alarm_pending (alarm_pending),
    .alarm_irq     (alarm_irq)
  );

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (alarm_pending !== it.exp || alarm_irq !== it.exp) begin
        bad++;
        $display("FAIL %s: pending=%0b irq=%0b expected=%0b",
                 it.tag, alarm_pending, alarm_irq, it.exp);
      end
    end
  end

  task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d,
                          input logic [4:0] mo, input logic [11:0] y);
    n_sec = s; n_min = m; n_hour = h; n_mday = d; n_mon = mo; n_year = y;
  endtask

  // driver: one rising edge per call, then queue the expected flag value
  task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d,
                      input bit stb, input bit exp, input string tag);
    @(negedge clk);
    cur_sec = n_sec; cur_min = n_min; cur_hour = n_hour;
    cur_mday = n_mday; cur_mon = n_mon; cur_year = n_year;
    wr_en = we; wr_addr = a; wr_data = d; sec_strobe = stb;
    @(posedge clk);
    sb_q.push_back('{exp, tag});
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit exp,
                    input string tag);
    step(1'b1, a, d, 1'b0, exp, tag);
  endtask

  task automatic tick(input bit exp, input string tag);
    step(1'b0, 3'd0, 16'h0, 1'b1, exp, tag);
  endtask

  task automatic clear_flag(input string tag);
    wr(3'd7, 16'h0002, 1'b0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, "R1 reset state");
    // R1: reset alarm fields are zero, so seconds 00 matches
    set_time(7'h00, 7'h00, 6'h00, 6'h00, 5'h00, 12'h000);
    wr(3'd0, 16'h0041, 1'b0, "R1 ctrl write");
    tick(1'b1, "R1 zero seconds match");
    clear_flag("R9 clear after R1");

    // R2: seconds stored as low 7 bits (0xD9 -> 0x59)
    wr(3'd1, 16'h00D9, 1'b0, "R2 sec write");
    set_time(7'h59, 7'h00, 6'h00, 6'h00, 5'h00, 12'h000);
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, "R6 no strobe no alarm");
    step(1'b0, 3'd0, 16'h0, 1'b0, 1'b0, "R6 no strobe no alarm 2");
    tick(1'b1, "R2 masked seconds match");
    // R8 sticky across a non-matching strobe
    set_time(7'h10, 7'h00, 6'h00, 6'h00, 5'h00, 12'h000);
    tick(1'b1, "R8 sticky on mismatch");
    wr(3'd7, 16'h0001, 1'b1, "R9 bit1 clear has no effect");
    clear_flag("R9 clear");

    // R3: minutes disabled, mismatch ignored
    wr(3'd2, 16'h0030, 1'b0, "R3 min write");
    set_time(7'h59, 7'h10, 6'h00, 6'h00, 5'h00, 12'h000);
    tick(1'b1, "R3 disabled minutes ignored");
    clear_flag("R9 clear R3a");
    wr(3'd0, 16'h0043, 1'b0, "R3 enable minutes");
    tick(1'b0, "R3 enabled minutes mismatch");
    set_time(7'h59, 7'h30, 6'h00, 6'h00, 5'h00, 12'h000);
    tick(1'b1, "R3 sec and min match");
    clear_flag("R9 clear R3b");

    // R4: no global enable
    wr(3'd0, 16'h0003, 1'b0, "R4 ctrl");
    tick(1'b0, "R4 global off");
    // R5: global only, no fields
    wr(3'd0, 16'h0040, 1'b0, "R5 ctrl");
    tick(1'b0, "R5 no field enabled");

    // R2/R3: hours, day, month (hour 0xE3 -> 0x23)
    wr(3'd3, 16'h00E3, 1'b0, "R2 hour write");
    wr(3'd4, 16'h0031, 1'b0, "R2 day write");
    wr(3'd5, 16'h0012, 1'b0, "R2 month write");
    wr(3'd0, 16'h005C, 1'b0, "R3 hour/day/month ctrl");
    set_time(7'h00, 7'h00, 6'h23, 6'h31, 5'h11, 12'h000);
    tick(1'b0, "R3 month mismatch");
    set_time(7'h00, 7'h00, 6'h23, 6'h31, 5'h12, 12'h000);
    tick(1'b1, "R3 hour day month match");
    clear_flag("R9 clear hdm");

    // R7: whole year compare, 0xF123 stored as 0x123
    wr(3'd6, 16'hF123, 1'b0, "R7 year write");
    wr(3'd0, 16'h0060, 1'b0, "R7 ctrl");
    set_time(7'h00, 7'h00, 6'h00, 6'h00, 5'h00, 12'h023);
    tick(1'b0, "R7 hundreds digit differs");
    set_time(7'h00, 7'h00, 6'h00, 6'h00, 5'h00, 12'h123);
    tick(1'b1, "R7 year match");

    // R10: strobe match with clear in same cycle, set wins
    step(1'b1, 3'd7, 16'h0002, 1'b1, 1'b1, "R10 set beats clear");
    clear_flag("R10 clear alone");

    // R11: same-cycle write uses old settings
    wr(3'd0, 16'h0041, 1'b0, "R11 ctrl");
    set_time(7'h59, 7'h00, 6'h00, 6'h00, 5'h00, 12'h000);
    step(1'b1, 3'd1, 16'h0010, 1'b1, 1'b1, "R11 old seconds used");
    clear_flag("R11 clear");
    tick(1'b0, "R11 new seconds in force");
    step(1'b1, 3'd0, 16'h0000, 1'b1, 1'b0, "R11 old ctrl used, no match");
    set_time(7'h10, 7'h00, 6'h00, 6'h00, 5'h00, 12'h000);
    tick(1'b0, "R4 ctrl cleared no alarm");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule